// File: doc/BRIEF.md
# Bridge Side Reset Readiness Controller

This block keeps a ready/not-ready state for each of the two sides of a non-transparent bridge: the near side, which faces the internal root, and the far side, which faces the external root. A side in the not-ready state has its incoming accesses refused by downstream gating logic, which is not part of this block. That state lets one root configure the bridge before any traffic arrives from the other root.

A reset seen on one side can block the opposite side, depending on that side's action controls. Software clears a side back to ready by writing its ready strobe. The device fundamental reset is the block's synchronous active-low reset. After it, the sides take a preset pattern: by default the far side is not ready, so the internal root configures the bridge. The parameter can flip this pattern so that the external root does the setup instead.

The active-low external bridge reset pin is synchronized and edge-detected. When non-transparent mode is active, a falling edge on it counts as a reset on the far side. If either side asks for propagation, that edge also raises a one-cycle request for a device-wide fundamental reset.

Top module: `bridge_ready_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `not_ready` takes `NOT_READY_INIT` after that edge (default 2'b10: bit 1 = far side not ready, bit 0 = near side ready), and `fund_rst_req` is 0.
- R2: A side becomes not ready one edge after a cycle in which `hot_rst_det` of the opposite side is high, provided the side's `act_en` is 1 and its `act_code` is 2'b01. Index 0 is the near side and index 1 is the far side.
- R3: With a side's `act_en` at 0, an opposite-side reset leaves that side's state unchanged.
- R4: An `act_code` of 2'b00 (no action) or of a reserved value (2'b10 or 2'b11) leaves the side's state unchanged on an opposite-side reset.
- R5: A high `ready_wr` bit returns that side to ready one edge later.
- R6: When a blocking reset event and `ready_wr` hit the same side in the same cycle, the side ends not ready.
- R7: With `ntb_mode_en` high, a falling edge on `ext_rst_n` counts as a far-side reset. If the pin is driven low before edge k, its effect on `not_ready[0]` is visible after edge k+2.
- R8: With `ntb_mode_en` low, edges on `ext_rst_n` change no state and raise no `fund_rst_req`.
- R9: A counted falling edge, with `prop_ext` nonzero on either side, makes `fund_rst_req` high for exactly one cycle, after edge k+2.
- R10: With `prop_ext` equal to 2'b00, no `fund_rst_req` is raised.
- R11: Only the falling edge counts. Holding the pin low or raising it causes no further event.
- R12: Without an event or a write, each side's state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device fundamental reset |
| ext_rst_n | input | 1 | Asynchronous active-low external bridge reset pin |
| ntb_mode_en | input | 1 | Non-transparent mode active |
| hot_rst_det | input | 2 | Per-side hot-reset detect pulse |
| act_en | input | 2 | Per-side reset action enable |
| act_code | input | 2x2 | Per-side reset action code |
| prop_ext | input | 2 | Per-side propagate-external-reset control |
| ready_wr | input | 2 | Per-side software write back to ready |
| not_ready | output | 2 | Per-side not-ready state |
| fund_rst_req | output | 1 | One-cycle device fundamental reset request |

## Verification
The bench works through each reserved action code and checks that none of them blocks; a design that decoded only the low code bit would block wrongly on 2'b11. It collides a software ready write with a blocking event in the same cycle, where a design with the priority reversed would leave the side ready. It also measures the exact pin-to-output latency and holds the pin low for many cycles. A level-sensitive detector would keep re-blocking the side and repeat the reset request, and a design that skipped the mode gate would react to the pin outside non-transparent mode.

// File: rtl/bridge_rst_pkg.sv
// Shared constants and types for the bridge reset readiness controller.
// Assumes exactly two bridge sides: index 0 near (internal), index 1 far (external).
package bridge_rst_pkg;
    localparam int NUM_SIDES = 2;
    localparam int ACT_W     = 2;
    localparam int SIDE_NEAR = 0;
    localparam int SIDE_FAR  = 1;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE  = 2'b00,
        ACT_BLOCK = 2'b01
    } act_code_e;
endpackage

// File: rtl/ext_pin_sync.sv
// Synchronizes an asynchronous active-low pin and emits a one-cycle pulse on
// its synchronized falling edge. Stages reset to 1 (pin idle high), so a pin
// already low when reset ends raises one pulse once it has passed through.
module ext_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_pulse
);
    localparam int TOTAL = STAGES + 1;

    logic [TOTAL-1:0] chain;

    // Shift the pin through the synchronizer plus one edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[TOTAL-2:0], pin_n};
    end

    // Falling edge: the older sample is high and the newer one is low.
    assign fall_pulse = chain[TOTAL-1] & ~chain[TOTAL-2];
endmodule

// File: rtl/side_mode_reg.sv
// Holds one side's not-ready state. A blocking reset event on the opposite
// side sets it; a software ready write clears it; the event wins a tie.
// Assumes opp_evt is already a single-cycle event.
module side_mode_reg
    import bridge_rst_pkg::*;
#(
    parameter logic INIT_NOT_READY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opp_evt,
    input  logic             act_en,
    input  logic [ACT_W-1:0] act_code,
    input  logic             ready_wr,
    output logic             not_ready
);
    logic block_now;

    // Only the enabled block code acts; reserved codes behave as no action.
    assign block_now = opp_evt & act_en & (act_code == ACT_BLOCK);

    // Update the mode: block first, then software release, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         not_ready <= INIT_NOT_READY;
        else if (block_now) not_ready <= 1'b1;
        else if (ready_wr)  not_ready <= 1'b0;
    end
endmodule

// File: rtl/bridge_ready_ctrl.sv
// Top of the bridge side reset readiness controller. Maps reset events to the
// opposite side's mode register and escalates a counted external pin edge into
// a device fundamental reset request. Assumes the hot-reset detects are
// single-cycle pulses already in the clk domain.
module bridge_ready_ctrl
    import bridge_rst_pkg::*;
#(
    parameter int                   SYNC_STAGES    = 2,
    parameter logic [NUM_SIDES-1:0] NOT_READY_INIT = 2'b10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ext_rst_n,
    input  logic                            ntb_mode_en,
    input  logic [NUM_SIDES-1:0]            hot_rst_det,
    input  logic [NUM_SIDES-1:0]            act_en,
    input  logic [NUM_SIDES-1:0][ACT_W-1:0] act_code,
    input  logic [NUM_SIDES-1:0]            prop_ext,
    input  logic [NUM_SIDES-1:0]            ready_wr,
    output logic [NUM_SIDES-1:0]            not_ready,
    output logic                            fund_rst_req
);
    logic                 pin_fall;
    logic                 ext_evt;
    logic [NUM_SIDES-1:0] side_evt;

    ext_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (ext_rst_n),
        .fall_pulse (pin_fall)
    );

    // The pin counts only in non-transparent mode.
    assign ext_evt = pin_fall & ntb_mode_en;

    // Collect reset events per side; the pin belongs to the far side.
    always_comb begin
        side_evt           = hot_rst_det;
        side_evt[SIDE_FAR] = hot_rst_det[SIDE_FAR] | ext_evt;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        side_mode_reg #(.INIT_NOT_READY(NOT_READY_INIT[s])) u_mode (
            .clk       (clk),
            .rst_n     (rst_n),
            .opp_evt   (side_evt[NUM_SIDES-1-s]),
            .act_en    (act_en[s]),
            .act_code  (act_code[s]),
            .ready_wr  (ready_wr[s]),
            .not_ready (not_ready[s])
        );
    end

    // Register the escalation request as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fund_rst_req <= 1'b0;
        else        fund_rst_req <= ext_evt & (|prop_ext);
    end
endmodule

// File: rtl/bridge_ready_ctrl_chk.sv
// Property checker for bridge_ready_ctrl, attached by bind below.
module bridge_ready_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ntb_mode_en,
    input logic       ext_evt,
    input logic [1:0] hot_rst_det,
    input logic [1:0] act_en,
    input logic [1:0][1:0] act_code,
    input logic [1:0] prop_ext,
    input logic [1:0] ready_wr,
    input logic [1:0] not_ready,
    input logic       fund_rst_req
);
    p_block_near_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_rst_det[1] && act_en[0] && act_code[0] == 2'b01) |=> not_ready[0]);
    p_block_far_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_rst_det[0] && act_en[1] && act_code[1] == 2'b01) |=> not_ready[1]);
    p_pin_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_evt && act_en[0] && act_code[0] == 2'b01) |=> not_ready[0]);
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_wr[1] && !hot_rst_det[0]) |=> !not_ready[1]);
    p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ntb_mode_en |-> !ext_evt);
    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fund_rst_req |=> !fund_rst_req);
    p_no_prop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_ext == 2'b00) |=> !fund_rst_req);
    p_hold_near_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_rst_det[1] && !ext_evt && !ready_wr[0]) |=> $stable(not_ready[0]));
    p_hold_far_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_rst_det[0] && !ready_wr[1]) |=> $stable(not_ready[1]));
endmodule

bind bridge_ready_ctrl bridge_ready_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ntb_mode_en  (ntb_mode_en),
    .ext_evt      (ext_evt),
    .hot_rst_det  (hot_rst_det),
    .act_en       (act_en),
    .act_code     (act_code),
    .prop_ext     (prop_ext),
    .ready_wr     (ready_wr),
    .not_ready    (not_ready),
    .fund_rst_req (fund_rst_req)
);

// File: tb/bridge_ready_ctrl_tb.sv
module bridge_ready_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [1:0] nr;
        logic       req;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst_n = 1'b1;
    logic ntb_mode_en = 1'b0;
    logic [1:0] hot_rst_det = '0;
    logic [1:0] act_en = '0;
    logic [1:0][1:0] act_code = '0;
    logic [1:0] prop_ext = '0;
    logic [1:0] ready_wr = '0;
    logic [1:0] not_ready;
    logic       fund_rst_req;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    // Reference state, built from the requirements.
    logic [1:0] m_nr = 2'b10;
    logic [2:0] m_pin = 3'b111;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_ready_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .ntb_mode_en(ntb_mode_en),
        .hot_rst_det(hot_rst_det), .act_en(act_en), .act_code(act_code),
        .prop_ext(prop_ext), .ready_wr(ready_wr), .not_ready(not_ready),
        .fund_rst_req(fund_rst_req)
    );

    // Driver: predict the state after the coming edge and queue it.
    task automatic step(input string tag);
        exp_t e;
        logic ev_ext;
        logic [1:0] ev;
        logic req;
        if (!rst_n) begin
            m_nr = 2'b10;
            m_pin = 3'b111;
            req = 1'b0;
        end else begin
            ev_ext = m_pin[2] & ~m_pin[1] & ntb_mode_en;
            ev = {hot_rst_det[1] | ev_ext, hot_rst_det[0]};
            for (int s = 0; s < 2; s++) begin
                if (act_en[s] && act_code[s] == 2'b01 && ev[1-s]) m_nr[s] = 1'b1;
                else if (ready_wr[s]) m_nr[s] = 1'b0;
            end
            req = ev_ext & (|prop_ext);
            m_pin = {m_pin[1:0], ext_rst_n};
        end
        e.nr = m_nr;
        e.req = req;
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
        hot_rst_det = '0;
        ready_wr = '0;
    endtask

    // Monitor: compare each result after the edge it belongs to.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (not_ready !== e.nr) begin
                errors++;
                $display("FAIL %s not_ready actual %b expected %b", e.tag, not_ready, e.nr);
            end
            checks++;
            if (fund_rst_req !== e.req) begin
                errors++;
                $display("FAIL %s fund_rst_req actual %b expected %b", e.tag, fund_rst_req, e.req);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
            begin
                step("R1"); step("R1");
                rst_n = 1'b1;
                step("R1");
                // R5: release the far side.
                ready_wr = 2'b10; step("R5");
                // R2: far side hot reset blocks the near side.
                act_en = 2'b11; act_code[0] = 2'b01; act_code[1] = 2'b01;
                hot_rst_det = 2'b10; step("R2");
                hot_rst_det = 2'b01; step("R2");
                ready_wr = 2'b11; step("R5");
                // R4: no-action and reserved codes.
                for (int c = 0; c < 4; c++) begin
                    if (c != 1) begin
                        act_code[0] = c[1:0]; act_code[1] = c[1:0];
                        hot_rst_det = 2'b11; step("R4");
                    end
                end
                // R3: enable off.
                act_code[0] = 2'b01; act_code[1] = 2'b01; act_en = 2'b00;
                hot_rst_det = 2'b11; step("R3");
                step("R12");
                // R6: event and write in the same cycle.
                act_en = 2'b11;
                hot_rst_det = 2'b10; ready_wr = 2'b01; step("R6");
                ready_wr = 2'b01; step("R5");
                // R7, R10: counted pin edge, no propagation.
                ntb_mode_en = 1'b1; prop_ext = 2'b00;
                ext_rst_n = 1'b0;
                repeat (6) step("R7");
                repeat (4) step("R11");
                ready_wr = 2'b01; step("R10");
                // R9: pin edge with propagation on the far side.
                ext_rst_n = 1'b1; repeat (4) step("R11");
                prop_ext = 2'b10; act_en = 2'b00;
                ext_rst_n = 1'b0; repeat (8) step("R9");
                // R8: mode off, pin edges ignored.
                ext_rst_n = 1'b1; repeat (4) step("R8");
                ntb_mode_en = 1'b0; act_en = 2'b11; prop_ext = 2'b11;
                ext_rst_n = 1'b0; repeat (6) step("R8");
                ext_rst_n = 1'b1; repeat (4) step("R12");
                step("R12");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule